// File: doc/BRIEF.md
# Buffered 8-bit PWM Timer

This block generates a pulse-width-modulated output from an 8-bit up counter. The counter advances on a selectable clock-enable tick. It wraps at a power-of-two period of 64, 128 or 256 counts, and every wrap sends a one-cycle interrupt pulse. The output flip-flop inverts at two points in each cycle: when the counter reaches the compare value, and at the wrap. The compare value therefore sets the duty cycle and the period select sets the cycle length.

The compare value is written over a simple bus port. With buffering enabled, a write first goes to a holding register. The holding register is copied into the active compare register only at the next wrap, so the duty cycle changes on a clean period boundary. With buffering disabled, a write reaches the active register at once. Prescaling is done outside the block. Three tick-enable inputs (every clock, every fourth clock, every sixteenth clock) are supplied, and a 2-bit field picks one of them.

Top module: `pwm8_timer`

## Requirements
- R1: After reset, `pwm_out` and `ovf_irq` are 0, the counter is 0 and both compare registers are 0.
- R2: With a tick on every clock, `ovf_irq` pulses once every 2^n clocks. Period code `per_sel` 2'b01 gives n=6, 2'b10 gives n=7, 2'b11 gives n=8, and the reserved code 2'b00 behaves as n=8.
- R3: On the tick where the counter is at 2^n-1 (or above it), the counter returns to 0. On the next cycle `ovf_irq` is high for exactly one clock, and `pwm_out` inverts if inversion is enabled.
- R4: On the tick that moves the counter to a value equal to the active compare value, `pwm_out` inverts if inversion is enabled. With a tick every clock, this inversion comes exactly C clocks after the wrap, for a compare value C.
- R5: `clk_sel` 2'b01 counts on `tick_div1`, 2'b10 on `tick_div4` and 2'b11 on `tick_div16`. Code 2'b00 selects no source, so the counter does not advance.
- R6: While `run` is low, the counter is held at 0, no match or wrap event occurs, and `pwm_out` keeps its value. After `run` rises with a tick every clock, the first `ovf_irq` comes 2^n clocks later.
- R7: While `ff_en` is low, `pwm_out` never changes. `ovf_irq` keeps pulsing.
- R8: With `buf_en` low, a write (`wr_en` high) sets the active compare value from the next clock on.
- R9: With `buf_en` high, a write goes only to the holding register. The active compare value takes the holding value at the next wrap and stays unchanged at all other times.
- R10: When a match and a wrap fall on the same tick (compare value 0), `pwm_out` inverts only once.
- R11: A compare value of 2^n or more never matches, so the output inverts only at wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable; low holds the counter at zero |
| tick_div1 | input | 1 | Tick enable, every clock |
| tick_div4 | input | 1 | Tick enable, every fourth clock |
| tick_div16 | input | 1 | Tick enable, every sixteenth clock |
| clk_sel | input | 2 | Tick source: 01 div1, 10 div4, 11 div16, 00 none |
| per_sel | input | 2 | Period: 01 2^6, 10 2^7, 11 or 00 2^8 |
| buf_en | input | 1 | Compare write goes through the holding register |
| ff_en | input | 1 | Output inversion enable |
| wr_en | input | 1 | Compare register write strobe |
| wr_data | input | 8 | Compare value to write |
| pwm_out | output | 1 | PWM output |
| ovf_irq | output | 1 | One-cycle pulse after each wrap |

## Verification
The compare match and the period wrap can land on the same tick. This happens whenever the compare value is 0, because the value after the wrap is 0. The bench writes 0 and checks two things: the output inverts once per period, so the gap from one wrap to the next output change is the full period, and the reference model flags any double inversion on the cycle it happens. A buffered write made in the same window as a wrap is also covered. The bench writes right after a wrap and checks that the old value is used for the current period and the new value for the following one.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int CW     = 8;   // counter and compare width
  localparam int NTAP   = 3;   // number of prescaled tick sources
  localparam int SEL_W  = 2;   // width of the select fields

  typedef enum logic [SEL_W-1:0] {
    TSRC_NONE  = 2'b00,
    TSRC_DIV1  = 2'b01,
    TSRC_DIV4  = 2'b10,
    TSRC_DIV16 = 2'b11
  } tick_src_e;

  // Exponent of the period for a period code; code 0 falls back to full width.
  function automatic int period_exp(input logic [SEL_W-1:0] code, input int w);
    case (code)
      2'b01:   period_exp = w - 2;
      2'b10:   period_exp = w - 1;
      default: period_exp = w;
    endcase
  endfunction

  // Last count value before the wrap, i.e. 2^n - 1.
  function automatic int period_last(input logic [SEL_W-1:0] code, input int w);
    period_last = (1 << period_exp(code, w)) - 1;
  endfunction

endpackage

// File: rtl/pwm8_tick_sel.sv
module pwm8_tick_sel
  import pwm8_pkg::*;
#(
  parameter int N = NTAP
) (
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             tick_en
);

  logic [N:0] src_vec;  // index 0 is the "no source" slot

  assign src_vec[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_tap
      assign src_vec[g+1] = taps[g];
    end
  endgenerate

  always_comb begin
    tick_en = 1'b0;
    if (run && (int'(sel) <= N)) tick_en = src_vec[sel];
  end

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
#(
  parameter int W = CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] per_sel,
  input  logic [W-1:0]     cmp,
  output logic [W-1:0]     cnt,
  output logic             ovf_ev,
  output logic             match_ev
);

  logic [W-1:0] last_val;
  logic         at_end;
  logic [W-1:0] nxt;

  always_comb begin
    last_val = W'(period_last(per_sel, W));
    // ">=" so that a period shortened while counting still wraps at once
    at_end   = (cnt >= last_val);
    nxt      = at_end ? '0 : cnt + 1'b1;
    ovf_ev   = tick_en && at_end;
    match_ev = tick_en && (nxt == cmp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick_en) cnt <= nxt;
  end

endmodule

// File: rtl/pwm8_cmp_reg.sv
module pwm8_cmp_reg
  import pwm8_pkg::*;
#(
  parameter int W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         buf_en,
  input  logic         ovf_ev,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] hold_q
);

  logic         load_direct;
  logic         load_shift;

  always_comb begin
    load_direct = wr_en && !buf_en;
    load_shift  = ovf_ev && buf_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_en) begin
      hold_q <= wr_data;
    end
  end

  // The shift uses the holding value from before a same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (load_direct) begin
      cmp_q <= wr_data;
    end else if (load_shift) begin
      cmp_q <= hold_q;
    end
  end

endmodule

// File: rtl/pwm8_out_ff.sv
module pwm8_out_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic ff_en,
  input  logic ovf_ev,
  input  logic match_ev,
  output logic toggle,
  output logic pwm_out,
  output logic ovf_irq
);

  // One inversion even when both events coincide.
  assign toggle = ff_en && (ovf_ev || match_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_out <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      if (toggle) pwm_out <= ~pwm_out;
      ovf_irq <= ovf_ev;
    end
  end

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int W = CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_div1,
  input  logic             tick_div4,
  input  logic             tick_div16,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [SEL_W-1:0] per_sel,
  input  logic             buf_en,
  input  logic             ff_en,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic             pwm_out,
  output logic             ovf_irq
);

  // Named internal events, visible to the bound checker.
  logic [NTAP-1:0] taps;
  logic            tick_en;
  logic [W-1:0]    cnt;
  logic [W-1:0]    cmp_q;
  logic [W-1:0]    hold_q;
  logic            ovf_ev;
  logic            match_ev;
  logic            toggle;

  assign taps = {tick_div16, tick_div4, tick_div1};

  pwm8_tick_sel #(.N(NTAP)) u_tick (
    .taps    (taps),
    .sel     (clk_sel),
    .run     (run),
    .tick_en (tick_en)
  );

  pwm8_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick_en  (tick_en),
    .per_sel  (per_sel),
    .cmp      (cmp_q),
    .cnt      (cnt),
    .ovf_ev   (ovf_ev),
    .match_ev (match_ev)
  );

  pwm8_cmp_reg #(.W(W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .buf_en  (buf_en),
    .ovf_ev  (ovf_ev),
    .cmp_q   (cmp_q),
    .hold_q  (hold_q)
  );

  pwm8_out_ff u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ff_en    (ff_en),
    .ovf_ev   (ovf_ev),
    .match_ev (match_ev),
    .toggle   (toggle),
    .pwm_out  (pwm_out),
    .ovf_irq  (ovf_irq)
  );

endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic [1:0]   clk_sel,
  input logic         buf_en,
  input logic         ff_en,
  input logic         tick_en,
  input logic         ovf_ev,
  input logic         match_ev,
  input logic [W-1:0] cmp_q,
  input logic         pwm_out,
  input logic         ovf_irq
);

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_irq);

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);

  assert_no_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00) |-> !tick_en);

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ovf_irq && $stable(pwm_out)));

  assert_ff_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_en |=> $stable(pwm_out));

  assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !ovf_ev) |=> $stable(cmp_q));

  assert_single_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && match_ev && ff_en) |=> (pwm_out != $past(pwm_out)));

endmodule

bind pwm8_timer pwm8_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .clk_sel  (clk_sel),
  .buf_en   (buf_en),
  .ff_en    (ff_en),
  .tick_en  (tick_en),
  .ovf_ev   (ovf_ev),
  .match_ev (match_ev),
  .cmp_q    (cmp_q),
  .pwm_out  (pwm_out),
  .ovf_irq  (ovf_irq)
);

// File: tb/pwm8_timer_tb.sv
module pwm8_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       tick_div1 = 1'b0, tick_div4 = 1'b0, tick_div16 = 1'b0;
  logic [1:0] clk_sel = 2'b01;
  logic [1:0] per_sel = 2'b01;
  logic       buf_en = 1'b0, ff_en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, ovf_irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwm8_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .tick_div1(tick_div1), .tick_div4(tick_div4), .tick_div16(tick_div16),
    .clk_sel(clk_sel), .per_sel(per_sel), .buf_en(buf_en), .ff_en(ff_en),
    .wr_en(wr_en), .wr_data(wr_data), .pwm_out(pwm_out), .ovf_irq(ovf_irq)
  );

  // Prescaler taps
  int pre = 0;
  always @(negedge clk) begin
    pre = (pre + 1) % 16;
    tick_div1  <= 1'b1;
    tick_div4  <= (pre % 4) == 0;
    tick_div16 <= (pre == 0);
  end

  // Behavioural reference model
  int    m_cnt = 0, m_cmp = 0, m_hold = 0;
  bit    m_pwm = 0, m_irq = 0;
  string m_tag = "R1";

  always @(posedge clk) begin
    int  per;
    bit  tk, ov, mt;
    int  nx, old_hold;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_hold = 0; m_pwm = 0; m_irq = 0; m_tag = "R1";
    end else begin
      per = (per_sel == 2'b01) ? 64 : (per_sel == 2'b10) ? 128 : 256;
      case (clk_sel)
        2'b01:   tk = tick_div1;
        2'b10:   tk = tick_div4;
        2'b11:   tk = tick_div16;
        default: tk = 0;
      endcase
      tk = tk && run;
      ov = 0; mt = 0;
      if (!run) m_cnt = 0;
      else if (tk) begin
        if (m_cnt >= per - 1) begin ov = 1; nx = 0; end
        else nx = m_cnt + 1;
        mt = (nx == m_cmp);
        m_cnt = nx;
      end
      if ((ov || mt) && ff_en) m_pwm = !m_pwm;
      m_irq = ov;
      old_hold = m_hold;
      if (wr_en) begin
        m_hold = wr_data;
        if (!buf_en) m_cmp = wr_data;
      end
      if (ov && buf_en && !(wr_en && !buf_en)) m_cmp = old_hold;
      if (ov && mt) m_tag = "R10";
      else if (ov) m_tag = "R3";
      else if (mt) m_tag = "R4";
      else if (!run) m_tag = "R6";
      else if (!ff_en) m_tag = "R7";
      else m_tag = "R5";
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (pwm_out !== m_pwm || ovf_irq !== m_irq) begin
        bad++;
        $display("FAIL %s model: pwm=%0b irq=%0b expected pwm=%0b irq=%0b",
                 m_tag, pwm_out, ovf_irq, m_pwm, m_irq);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ovf_irq) return;
    end
  endtask

  task automatic irq_gap(output int n);
    wait_irq();
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (ovf_irq) return;
    end
  endtask

  // Clocks from a wrap to the next output change, with an optional write
  task automatic flip_gap(input bit do_wr, input logic [7:0] d, output int n);
    bit p0;
    wait_irq();
    p0 = pwm_out;
    if (do_wr) begin wr_en = 1'b1; wr_data = d; end
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      wr_en = 1'b0;
      if (pwm_out != p0) return;
    end
  endtask

  task automatic write_cmp(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, irqs;
    bit p0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
    check(ovf_irq == 1'b0, "R1 irq after reset", ovf_irq, 0);
    rst_n = 1'b1;

    // R4: match position
    write_cmp(8'd20);
    run = 1'b1;
    flip_gap(0, 8'd0, n);
    check(n == 20, "R4 match gap", n, 20);

    // R2: period codes
    per_sel = 2'b01; wait_irq(); irq_gap(n); check(n == 64,  "R2 code 01", n, 64);
    per_sel = 2'b10; wait_irq(); irq_gap(n); check(n == 128, "R2 code 10", n, 128);
    per_sel = 2'b11; wait_irq(); irq_gap(n); check(n == 256, "R2 code 11", n, 256);
    per_sel = 2'b00; wait_irq(); irq_gap(n); check(n == 256, "R2 code 00", n, 256);

    // R5: tick sources
    per_sel = 2'b01;
    clk_sel = 2'b10; wait_irq(); irq_gap(n); check(n == 256,  "R5 div4", n, 256);
    clk_sel = 2'b11; wait_irq(); irq_gap(n); check(n == 1024, "R5 div16", n, 1024);
    clk_sel = 2'b00;
    @(negedge clk);
    p0 = pwm_out; irqs = 0;
    repeat (600) begin @(negedge clk); if (ovf_irq) irqs++; end
    check(irqs == 0, "R5 no source irqs", irqs, 0);
    check(pwm_out == p0, "R5 no source pwm", pwm_out, p0);
    clk_sel = 2'b01;

    // R8: unbuffered write takes effect at once
    flip_gap(1, 8'd40, n);
    check(n == 40, "R8 direct write", n, 40);

    // R9: buffered write waits for the wrap
    buf_en = 1'b1;
    flip_gap(1, 8'd10, n);
    check(n == 40, "R9 old value kept", n, 40);
    flip_gap(0, 8'd0, n);
    check(n == 10, "R9 new value after wrap", n, 10);
    buf_en = 1'b0;

    // R11: compare beyond period
    flip_gap(1, 8'd100, n);
    check(n == 64, "R11 no match", n, 64);

    // R10: coincident match and wrap
    flip_gap(1, 8'd0, n);
    check(n == 64, "R10 single flip", n, 64);
    flip_gap(0, 8'd0, n);
    check(n == 64, "R10 single flip again", n, 64);

    // R7: inversion disabled
    write_cmp(8'd20);
    ff_en = 1'b0;
    @(negedge clk);
    p0 = pwm_out; irqs = 0;
    repeat (300) begin @(negedge clk); if (ovf_irq) irqs++; end
    check(pwm_out == p0, "R7 pwm frozen", pwm_out, p0);
    check(irqs >= 4, "R7 irq still pulses", irqs, 4);
    ff_en = 1'b1;

    // R6: run low holds output, restart from zero
    run = 1'b0;
    @(negedge clk);
    p0 = pwm_out; irqs = 0;
    repeat (200) begin @(negedge clk); if (ovf_irq) irqs++; end
    check(irqs == 0, "R6 no irq while stopped", irqs, 0);
    check(pwm_out == p0, "R6 pwm held", pwm_out, p0);
    run = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (ovf_irq) break;
    end
    check(n == 64, "R6 restart wrap", n, 64);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule